// File: doc/BRIEF.md
# Multicycle 16-bit Instruction Processor

This block is a small stored-program processor that runs one instruction at a time. It moves each instruction through a series of control states. Fetch and decode happen for every instruction. The address, operand, execute and writeback states are visited only when the opcode needs them. Its state is a program counter, an instruction register, a memory address register, a memory data register and eight 16-bit general registers. All traffic to the single-port, word-addressed memory passes through the two staging registers. Memory returns read data one clock after a read strobe.

The supported operations are register add, register bitwise AND, bitwise complement, a load from a base register plus a signed 6-bit offset, and a jump to the address held in a register. Any other opcode retires as a no-op. The program counter and the whole register file are brought out on debug ports so that a bench can observe them.

Top module: `mc16_cpu`

## Requirements
- R1: While `rst_n` is low at a rising edge, the processor clears the PC, the instruction register, both staging registers and all eight registers to zero. After `rst_n` goes high, the first instruction fetch reads address 0.
- R2: A fetch drives the PC onto `mem_addr`, pulses `mem_rd`, and takes the word returned one cycle later as the instruction. It then advances the PC by one, so instructions that do not jump are fetched from consecutive addresses.
- R3: The opcode is in bits [15:12], and decode turns it into a one-hot set of 16 lines. The encodings are add 4'b0001, AND 4'b0101, complement 4'b1001, load 4'b0110 and jump 4'b1100. Fields: destination [11:9], first source or base [8:6], second source [2:0], offset [5:0].
- R4: Add writes the sum of the first-source and second-source registers, modulo 2^16, into the destination register. The destination may also be a source.
- R5: AND writes the bitwise AND of the first-source and second-source registers into the destination register.
- R6: Complement writes the bitwise inverse of the first-source register into the destination register.
- R7: Load forms the address as the base register plus the 6-bit offset sign-extended to 16 bits, reads that word, and writes it into the destination register.
- R8: Jump loads the PC with the register selected by bits [8:6]. The next fetch reads that address, and the words after the jump are not executed.
- R9: Any other opcode changes no general register. The next fetch is from the following address.
- R10: Measured between consecutive instruction fetch strobes, an add, AND, complement or jump takes 6 cycles, a load takes 9 cycles and a no-op takes 5 cycles.
- R11: Every `mem_rd` pulse lasts exactly one cycle, and `mem_addr` holds its value through the following cycle while data returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Word address to memory, driven from the address staging register |
| mem_rd | output | 1 | Single-cycle read strobe |
| mem_rdata | input | 16 | Read data, valid the cycle after the strobe |
| dbg_pc | output | 16 | Current program counter |
| dbg_regs | output | 128 | All eight registers, register n at bits [16n+15:16n] |

## Verification
The assertions assume that reset is held low for at least one rising edge. They also assume that memory answers every read strobe with a registered word in the next cycle and never returns data without a strobe. The bench memory is a synchronous array that updates its output only on a strobe, which meets both assumptions. Each program keeps its code below word 16 and its data at word 16 or above. Because of this split, a load never reads an instruction word, and the fetch record used for the ordering and timing checks sees only instruction reads.

// File: rtl/mc16_pkg.sv
// Package mc16_pkg
// Purpose : shared widths, opcode encodings and controller state type for
//           the multicycle processor.
// Assumes : fixed 16-bit instruction format with the opcode in [15:12].
package mc16_pkg;

    localparam int WORD_W  = 16;
    localparam int NREG    = 8;
    localparam int RADDR_W = $clog2(NREG);
    localparam int OPC_W   = 4;
    localparam int NOPC    = 1 << OPC_W;
    localparam int OFS_W   = 6;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_JMP = 4'b1100;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR = 4'd0,
        ST_FETCH_READ = 4'd1,
        ST_FETCH_CAPT = 4'd2,
        ST_FETCH_IR   = 4'd3,
        ST_DECODE     = 4'd4,
        ST_EXECUTE    = 4'd5,
        ST_JUMP       = 4'd6,
        ST_EVAL_ADDR  = 4'd7,
        ST_OPND_READ  = 4'd8,
        ST_OPND_CAPT  = 4'd9,
        ST_STORE      = 4'd10
    } ctrl_state_t;

endpackage

// File: rtl/mc16_regfile.sv
// Module mc16_regfile
// Purpose : general register file with two combinational read ports and one
//           synchronous write port; all registers also exposed flattened.
// Assumes : synchronous active-low reset clears every register.
module mc16_regfile #(
    parameter int W    = 16,
    parameter int N    = 8,
    localparam int AW  = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  wa,
    input  logic [W-1:0]   wd,
    input  logic [AW-1:0]  ra,
    input  logic [AW-1:0]  rb,
    output logic [W-1:0]   rd_a,
    output logic [W-1:0]   rd_b,
    output logic [N*W-1:0] flat
);

    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // Purpose: hold register g, load it when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && (wa == AW'(g)))
                regs[g] <= wd;
        end
        assign flat[g*W +: W] = regs[g];
    end

    assign rd_a = regs[ra];
    assign rd_b = regs[rb];

    // R9: with no write enable the register contents stay put
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(flat));

    // R4: a write lands in the addressed register on the next edge
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs[$past(wa)] == $past(wd));

endmodule

// File: rtl/mc16_alu.sv
// Module mc16_alu
// Purpose : combinational add, AND and complement on two operands.
// Assumes : sel is one-hot {not, and, add}; an all-zero sel yields zero.
module mc16_alu #(
    parameter int W = 16
) (
    input  logic [2:0]   sel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    // Purpose: pick the operation named by the one-hot select.
    always_comb begin
        if (sel[0])
            y = a + b;
        else if (sel[1])
            y = a & b;
        else if (sel[2])
            y = ~a;
        else
            y = '0;
    end

endmodule

// File: rtl/mc16_ctrl.sv
// Module mc16_ctrl
// Purpose : controller state machine; decodes the opcode to one-hot lines
//           and sequences fetch, decode and only the phases an opcode needs.
// Assumes : memory returns read data one cycle after mem_rd.
module mc16_ctrl
    import mc16_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    output logic             mar_from_pc,
    output logic             mar_from_ea,
    output logic             mem_rd,
    output logic             mdr_ld,
    output logic             ir_ld,
    output logic             pc_inc,
    output logic             pc_jmp,
    output logic             rf_we,
    output logic             rf_from_mdr,
    output logic [2:0]       alu_sel
);

    ctrl_state_t     state, state_nx;
    logic [NOPC-1:0] dec_now, dec_q;

    // Purpose: 4-to-16 one-hot decode of the current opcode.
    always_comb dec_now = NOPC'(1) << opcode;

    // Purpose: advance the state and latch the decoded lines in decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH_ADDR;
            dec_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_DECODE)
                dec_q <= dec_now;
        end
    end

    // Purpose: next-state selection, branching on the active decode line.
    always_comb begin
        state_nx = ST_FETCH_ADDR;
        case (state)
            ST_FETCH_ADDR: state_nx = ST_FETCH_READ;
            ST_FETCH_READ: state_nx = ST_FETCH_CAPT;
            ST_FETCH_CAPT: state_nx = ST_FETCH_IR;
            ST_FETCH_IR:   state_nx = ST_DECODE;
            ST_DECODE: begin
                if (dec_now[OPC_ADD] || dec_now[OPC_AND] || dec_now[OPC_NOT])
                    state_nx = ST_EXECUTE;
                else if (dec_now[OPC_LDR])
                    state_nx = ST_EVAL_ADDR;
                else if (dec_now[OPC_JMP])
                    state_nx = ST_JUMP;
                else
                    state_nx = ST_FETCH_ADDR;
            end
            ST_EVAL_ADDR:  state_nx = ST_OPND_READ;
            ST_OPND_READ:  state_nx = ST_OPND_CAPT;
            ST_OPND_CAPT:  state_nx = ST_STORE;
            default:       state_nx = ST_FETCH_ADDR;
        endcase
    end

    // Purpose: control strobes as a function of the state.
    always_comb begin
        mar_from_pc = (state == ST_FETCH_ADDR);
        mar_from_ea = (state == ST_EVAL_ADDR);
        mem_rd      = (state == ST_FETCH_READ) || (state == ST_OPND_READ);
        mdr_ld      = (state == ST_FETCH_CAPT) || (state == ST_OPND_CAPT);
        ir_ld       = (state == ST_FETCH_IR);
        pc_inc      = (state == ST_FETCH_IR);
        pc_jmp      = (state == ST_JUMP);
        rf_we       = (state == ST_EXECUTE) || (state == ST_STORE);
        rf_from_mdr = (state == ST_STORE);
        alu_sel     = {dec_q[OPC_NOT], dec_q[OPC_AND], dec_q[OPC_ADD]};
    end

    // R3: execute is entered only with exactly one ALU decode line active
    assert_exec_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXECUTE) |-> $countones(alu_sel) == 1);

    // R2: a fetch read is always followed by a capture of the returned word
    assert_fetch_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_READ) |=> mdr_ld);

endmodule

// File: rtl/mc16_cpu.sv
// Module mc16_cpu
// Purpose : top of the multicycle processor; holds PC, IR, MAR and MDR and
//           connects controller, register file and ALU.
// Assumes : word-addressed memory answers mem_rd with data one cycle later.
module mc16_cpu
    import mc16_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [WORD_W-1:0]      mem_addr,
    output logic                   mem_rd,
    input  logic [WORD_W-1:0]      mem_rdata,
    output logic [WORD_W-1:0]      dbg_pc,
    output logic [NREG*WORD_W-1:0] dbg_regs
);

    logic [WORD_W-1:0] pc, ir, mar, mdr;
    logic [WORD_W-1:0] rd_a, rd_b, alu_y, wdata, eff_addr, ofs_ext;
    logic              mar_from_pc, mar_from_ea, mdr_ld, ir_ld;
    logic              pc_inc, pc_jmp, rf_we, rf_from_mdr;
    logic [2:0]        alu_sel;

    mc16_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .opcode      (ir[15:12]),
        .mar_from_pc (mar_from_pc),
        .mar_from_ea (mar_from_ea),
        .mem_rd      (mem_rd),
        .mdr_ld      (mdr_ld),
        .ir_ld       (ir_ld),
        .pc_inc      (pc_inc),
        .pc_jmp      (pc_jmp),
        .rf_we       (rf_we),
        .rf_from_mdr (rf_from_mdr),
        .alu_sel     (alu_sel)
    );

    mc16_regfile #(.W(WORD_W), .N(NREG)) i_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wa    (ir[11:9]),
        .wd    (wdata),
        .ra    (ir[8:6]),
        .rb    (ir[2:0]),
        .rd_a  (rd_a),
        .rd_b  (rd_b),
        .flat  (dbg_regs)
    );

    mc16_alu #(.W(WORD_W)) i_alu (
        .sel (alu_sel),
        .a   (rd_a),
        .b   (rd_b),
        .y   (alu_y)
    );

    // Purpose: sign-extend the offset field and form the load address.
    always_comb begin
        ofs_ext  = {{(WORD_W-OFS_W){ir[OFS_W-1]}}, ir[OFS_W-1:0]};
        eff_addr = rd_a + ofs_ext;
        wdata    = rf_from_mdr ? mdr : alu_y;
    end

    // Purpose: program counter, stepped after fetch or loaded on a jump.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (pc_jmp)
            pc <= rd_a;
        else if (pc_inc)
            pc <= pc + 1'b1;
    end

    // Purpose: memory address staging from PC or from the computed address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mar <= '0;
        else if (mar_from_pc)
            mar <= pc;
        else if (mar_from_ea)
            mar <= eff_addr;
    end

    // Purpose: memory data staging, capturing the word returned by memory.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mdr <= '0;
        else if (mdr_ld)
            mdr <= mem_rdata;
    end

    // Purpose: instruction register, loaded from MDR at the end of fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ir <= '0;
        else if (ir_ld)
            ir <= mdr;
    end

    assign mem_addr = mar;
    assign dbg_pc   = pc;

    // R2: the fetch step advances the PC by exactly one
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |=> pc == $past(pc) + 16'd1);

    // R8: a jump puts the selected register value into the PC
    assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_jmp |=> pc == $past(rd_a));

    // R9: outside the fetch step and a jump the PC does not move
    assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_inc || pc_jmp) |=> $stable(pc));

    // R11: a read strobe lasts one cycle
    assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R11: the address stays put in the cycle the data comes back
    assert_addr_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> $stable(mem_addr));

endmodule

// File: tb/test_mc16_cpu.sv
`timescale 1ns/1ps
module test_mc16_cpu;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  mem_addr;
    logic         mem_rd;
    logic [15:0]  mem_rdata = '0;
    logic [15:0]  dbg_pc;
    logic [127:0] dbg_regs;

    logic [15:0]  mem [256];
    int           n_checks = 0;
    int           n_fail = 0;
    int           cyc = 0;
    int           nf = 0;
    logic [15:0]  f_addr [32];
    int           f_cyc [32];

    always #4 clk = ~clk;

    mc16_cpu i_mc16_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .dbg_pc    (dbg_pc),
        .dbg_regs  (dbg_regs)
    );

    // memory model: registered read data one cycle after the strobe
    always @(posedge clk) begin
        if (mem_rd)
            mem_rdata <= mem[mem_addr[7:0]];
    end

    // cycle counter and record of instruction fetch strobes (code below 16)
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n)
            nf <= 0;
        else if (mem_rd && mem_addr < 16'd16 && nf < 32) begin
            f_addr[nf] <= mem_addr;
            f_cyc[nf]  <= cyc;
            nf         <= nf + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rget(input int i);
        return dbg_regs[16*i +: 16];
    endfunction

    function automatic logic [15:0] e_rrr(input logic [3:0] op, input int d, input int s1, input int s2);
        logic [2:0] dd = 3'(d);
        logic [2:0] a1 = 3'(s1);
        logic [2:0] a2 = 3'(s2);
        return {op, dd, a1, 3'b000, a2};
    endfunction

    function automatic logic [15:0] e_not(input int d, input int s);
        logic [2:0] dd = 3'(d);
        logic [2:0] a1 = 3'(s);
        return {4'b1001, dd, a1, 6'h3F};
    endfunction

    function automatic logic [15:0] e_ldr(input int d, input int b, input int off);
        logic [2:0] dd = 3'(d);
        logic [2:0] bb = 3'(b);
        logic [5:0] oo = 6'(off);
        return {4'b0110, dd, bb, oo};
    endfunction

    function automatic logic [15:0] e_jmp(input int b);
        logic [2:0] bb = 3'(b);
        return {4'b1100, 3'b000, bb, 6'b0};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic start();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_to(input logic [15:0] stop_at);
        int guard = 0;
        while (!(nf > 0 && f_addr[nf-1] == stop_at) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 2000, "R2", "program reached end fetch", 32'(guard), 32'd0);
    endtask

    // R1: reset state and first fetch address
    task automatic t_reset();
        clear_mem();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(dbg_pc == 16'h0, "R1", "pc in reset", 32'(dbg_pc), 32'h0);
        chk(dbg_regs == '0, "R1", "regs in reset", 32'(dbg_regs[31:0]), 32'h0);
        chk(mem_rd == 1'b0, "R1", "no read in reset", 32'(mem_rd), 32'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(nf >= 1 && f_addr[0] == 16'h0, "R1", "first fetch address", 32'(f_addr[0]), 32'h0);
    endtask

    // R4, R5, R2, R10: add, AND, wrap, destination equal to source
    task automatic t_alu();
        clear_mem();
        mem[16] = 16'h1234; mem[17] = 16'hF00F; mem[18] = 16'hFFFF;
        mem[0] = e_ldr(1, 0, 16);
        mem[1] = e_ldr(2, 0, 17);
        mem[2] = e_ldr(3, 0, 18);
        mem[3] = e_rrr(4'b0001, 4, 1, 2);
        mem[4] = e_rrr(4'b0101, 5, 1, 2);
        mem[5] = e_rrr(4'b0001, 6, 3, 3);
        mem[6] = e_rrr(4'b0001, 1, 1, 1);
        start();
        run_to(16'd7);
        chk(rget(4) == 16'h0243, "R4", "add carry out dropped", 32'(rget(4)), 32'h0243);
        chk(rget(6) == 16'hFFFE, "R4", "add wrap", 32'(rget(6)), 32'hFFFE);
        chk(rget(1) == 16'h2468, "R4", "dest equals source", 32'(rget(1)), 32'h2468);
        chk(rget(5) == 16'h1004, "R5", "and result", 32'(rget(5)), 32'h1004);
        for (int k = 0; k < 8; k++)
            chk(f_addr[k] == 16'(k), "R2", "sequential fetch", 32'(f_addr[k]), 32'(k));
        chk(f_cyc[1] - f_cyc[0] == 9, "R10", "load cycles", 32'(f_cyc[1] - f_cyc[0]), 32'd9);
        chk(f_cyc[4] - f_cyc[3] == 6, "R10", "add cycles", 32'(f_cyc[4] - f_cyc[3]), 32'd6);
        chk(f_cyc[5] - f_cyc[4] == 6, "R10", "and cycles", 32'(f_cyc[5] - f_cyc[4]), 32'd6);
    endtask

    // R6, R10: complement
    task automatic t_not();
        clear_mem();
        mem[16] = 16'h00FF;
        mem[0] = e_ldr(1, 0, 16);
        mem[1] = e_not(2, 1);
        mem[2] = e_not(3, 0);
        start();
        run_to(16'd3);
        chk(rget(2) == 16'hFF00, "R6", "not of value", 32'(rget(2)), 32'hFF00);
        chk(rget(3) == 16'hFFFF, "R6", "not of zero", 32'(rget(3)), 32'hFFFF);
        chk(f_cyc[2] - f_cyc[1] == 6, "R10", "not cycles", 32'(f_cyc[2] - f_cyc[1]), 32'd6);
    endtask

    // R7: base plus sign-extended offset, both signs and largest offset
    task automatic t_ldr();
        clear_mem();
        mem[16] = 16'h0040; mem[8'h3E] = 16'hBEEF; mem[8'h5F] = 16'h1357;
        mem[0] = e_ldr(1, 0, 16);
        mem[1] = e_ldr(2, 1, -2);
        mem[2] = e_ldr(3, 1, 31);
        start();
        run_to(16'd3);
        chk(rget(1) == 16'h0040, "R7", "load zero base", 32'(rget(1)), 32'h0040);
        chk(rget(2) == 16'hBEEF, "R7", "negative offset", 32'(rget(2)), 32'hBEEF);
        chk(rget(3) == 16'h1357, "R7", "largest offset", 32'(rget(3)), 32'h1357);
    endtask

    // R8, R10: jump skips words and fetches target
    task automatic t_jmp();
        clear_mem();
        mem[20] = 16'h0008;
        mem[0] = e_ldr(3, 0, 20);
        mem[1] = e_jmp(3);
        for (int k = 2; k < 8; k++) mem[k] = e_not(1, 0);
        mem[8] = e_rrr(4'b0001, 4, 3, 3);
        start();
        run_to(16'd9);
        chk(f_addr[2] == 16'h0008, "R8", "fetch after jump", 32'(f_addr[2]), 32'h8);
        chk(rget(1) == 16'h0000, "R8", "skipped words not run", 32'(rget(1)), 32'h0);
        chk(rget(4) == 16'h0010, "R8", "target executed", 32'(rget(4)), 32'h10);
        chk(f_cyc[2] - f_cyc[1] == 6, "R10", "jump cycles", 32'(f_cyc[2] - f_cyc[1]), 32'd6);
    endtask

    // R9, R10: unused opcodes leave registers untouched
    task automatic t_nop();
        clear_mem();
        mem[16] = 16'h5555;
        mem[0] = e_ldr(1, 0, 16);
        mem[1] = 16'h7E41;
        mem[2] = 16'h3E41;
        mem[3] = 16'hFFFF;
        start();
        run_to(16'd4);
        chk(rget(1) == 16'h5555, "R9", "source kept", 32'(rget(1)), 32'h5555);
        chk(rget(7) == 16'h0000, "R9", "named dest kept", 32'(rget(7)), 32'h0);
        chk(dbg_regs[127:32] == '0, "R9", "upper regs kept", 32'(dbg_regs[127:96]), 32'h0);
        for (int k = 1; k < 5; k++)
            chk(f_addr[k] == 16'(k), "R9", "fetch continues", 32'(f_addr[k]), 32'(k));
        chk(f_cyc[2] - f_cyc[1] == 5, "R10", "no-op cycles", 32'(f_cyc[2] - f_cyc[1]), 32'd5);
        chk(f_cyc[4] - f_cyc[3] == 5, "R10", "no-op cycles 2", 32'(f_cyc[4] - f_cyc[3]), 32'd5);
    endtask

    initial begin
        t_reset();
        t_alu();
        t_not();
        t_ldr();
        t_jmp();
        t_nop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule